// File: doc/BRIEF.md
# Byte-Wide Timing Register Load Port

This block is the host-side programming port for a bank of sixteen 12-bit timing registers. A host drives an 8-bit bus, two qualifier bits and a LOAD strobe that has no timing relation to the system clock. The falling edge of the strobe fixes the qualifiers: one bit selects an address write or a data write, and the other selects the low byte or the high nibble. The rising edge of the strobe then commits the bus value.

A data value reaches its register in two writes. The low byte goes to a staging register first. Writing the high nibble commits the full 12-bit word to the addressed register in a single cycle, so the timing logic downstream never sees a half-written value. An address write with the nibble-select bit set turns on auto-load. In that mode each committed word moves the address to the next register, which lets a host fill the whole bank after one address write.

All registers are visible in parallel to the timing counters. Register 0 is the status register, and it is also driven out on its own port. An active-low asynchronous clear puts every register back to its built-in default.

Top module: `tlp_load_port`

## Requirements
- R1: While `rst_ni` is low, register 0 reads 0 and register i (i = 1..15) reads (37*i + 100) mod 4096. `addr_o` reads 0, auto-load is off and the low-byte staging register is 0.
- R2: The qualifiers `sel_data_i` and `sel_hi_i` are sampled at the falling edge of `load_i`. Changes to them while `load_i` stays low have no effect on the write that follows.
- R3: An address write (`sel_data_i`=0) sets `addr_o` to `data_i[3:0]`. `data_i[7:4]` is ignored.
- R4: A data write with `sel_hi_i`=0 stores `data_i` in the staging register and leaves every timing register and `addr_o` unchanged.
- R5: A data write with `sel_hi_i`=1 sets the addressed register to {`data_i[3:0]`, staged byte} in a single update. `data_i[7:4]` is ignored, and no other register changes.
- R6: An address write with `sel_hi_i`=1 turns auto-load on. While auto-load is on, each high-nibble write increments `addr_o` by one, wrapping from 15 to 0.
- R7: An address write with `sel_hi_i`=0 turns auto-load off. With auto-load off, a high-nibble write leaves `addr_o` unchanged.
- R8: Without a rising edge on `load_i`, changes on `data_i`, `sel_data_i` and `sel_hi_i` change no register and do not change `addr_o`.
- R9: `status_o` always equals register 0, which is bits [11:0] of `regs_o`. Register i is `regs_o[12*i +: 12]`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous clear |
| load_i | input | 1 | Asynchronous load strobe, idle high |
| sel_data_i | input | 1 | 0 = address write, 1 = data write |
| sel_hi_i | input | 1 | 0 = low byte, 1 = high nibble; in an address write, 1 enables auto-load |
| data_i | input | 8 | Host data bus |
| regs_o | output | 192 | All sixteen 12-bit registers, flattened |
| status_o | output | 12 | Register 0 (status) |
| addr_o | output | 4 | Current register address |

## Verification
Every cycle, the assertions check how the synchronised strobe edges act on the state. An address commit loads the address and the auto-load flag. A low-byte commit changes no register. In auto-load mode a high-nibble commit steps the address. With no rising edge, the address, the mode and the register bank all hold. Some behaviours need the host-side sequence and are shown only by the bench scenarios: the 12-bit value assembled from two separate strobes, qualifiers that change while the strobe is low, wrap of the address from 15 to 0, and the defaults returning after a clear in mid-run.

// File: rtl/tlp_pkg.sv
package tlp_pkg;
  localparam int unsigned NREG = 16;
  localparam int unsigned RW   = 12;
  localparam int unsigned BW   = 8;

  function automatic logic [RW-1:0] def_val(input int unsigned idx);
    int unsigned v;
    v = (idx == 0) ? 0 : (37 * idx + 100) % (1 << RW);
    return v[RW-1:0];
  endfunction
endpackage

// File: rtl/tlp_sync.sv
module tlp_sync #(
  parameter int unsigned W       = 1,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] s1_q, s2_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_q <= RST_VAL;
      s2_q <= RST_VAL;
    end else begin
      s1_q <= d_i;
      s2_q <= s1_q;
    end
  end

  assign q_o = s2_q;
endmodule

// File: rtl/tlp_edge.sv
module tlp_edge #(
  parameter logic RST_VAL = 1'b1
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic lvl_i,
  output logic rise_o,
  output logic fall_o
);
  logic prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) prev_q <= RST_VAL;
    else         prev_q <= lvl_i;
  end

  assign rise_o = lvl_i & ~prev_q;
  assign fall_o = ~lvl_i & prev_q;
endmodule

// File: rtl/tlp_ctrl.sv
module tlp_ctrl #(
  parameter int unsigned NREG = tlp_pkg::NREG,
  parameter int unsigned RW   = tlp_pkg::RW,
  parameter int unsigned BW   = tlp_pkg::BW,
  localparam int unsigned AW  = $clog2(NREG),
  localparam int unsigned HW  = RW - BW
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          rise_i,
  input  logic          fall_i,
  input  logic          ad_i,
  input  logic          hi_i,
  input  logic [BW-1:0] din_i,
  output logic          q_ad_o,
  output logic          q_hi_o,
  output logic          auto_o,
  output logic [AW-1:0] addr_o,
  output logic          we_o,
  output logic [AW-1:0] wa_o,
  output logic [RW-1:0] wd_o
);
  logic          q_ad, q_hi, auto_q;
  logic [AW-1:0] addr_q;
  logic [BW-1:0] low_q;

  // qualifiers fixed at falling strobe edge
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      q_ad <= 1'b0;
      q_hi <= 1'b0;
    end else if (fall_i) begin
      q_ad <= ad_i;
      q_hi <= hi_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      addr_q <= '0;
      auto_q <= 1'b0;
      low_q  <= '0;
    end else if (rise_i) begin
      if (!q_ad) begin
        addr_q <= din_i[AW-1:0];
        auto_q <= q_hi;
      end else if (!q_hi) begin
        low_q <= din_i;
      end else if (auto_q) begin
        addr_q <= addr_q + AW'(1);
      end
    end
  end

  assign we_o   = rise_i & q_ad & q_hi;
  assign wa_o   = addr_q;
  assign wd_o   = {din_i[HW-1:0], low_q};
  assign q_ad_o = q_ad;
  assign q_hi_o = q_hi;
  assign auto_o = auto_q;
  assign addr_o = addr_q;
endmodule

// File: rtl/tlp_regbank.sv
module tlp_regbank #(
  parameter int unsigned NREG = tlp_pkg::NREG,
  parameter int unsigned RW   = tlp_pkg::RW,
  localparam int unsigned AW  = $clog2(NREG)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               we_i,
  input  logic [AW-1:0]      wa_i,
  input  logic [RW-1:0]      wd_i,
  output logic [NREG*RW-1:0] regs_o
);
  for (genvar i = 0; i < NREG; i++) begin : g_reg
    logic [RW-1:0] r_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                        r_q <= tlp_pkg::def_val(i);
      else if (we_i && wa_i == AW'(i))    r_q <= wd_i;
    end
    assign regs_o[i*RW +: RW] = r_q;
  end
endmodule

// File: rtl/tlp_load_port.sv
module tlp_load_port #(
  parameter int unsigned NREG = tlp_pkg::NREG,
  parameter int unsigned RW   = tlp_pkg::RW,
  parameter int unsigned BW   = tlp_pkg::BW,
  localparam int unsigned AW  = $clog2(NREG)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               load_i,
  input  logic               sel_data_i,
  input  logic               sel_hi_i,
  input  logic [BW-1:0]      data_i,
  output logic [NREG*RW-1:0] regs_o,
  output logic [RW-1:0]      status_o,
  output logic [AW-1:0]      addr_o
);
  localparam int unsigned SW = BW + 3;

  logic [SW-1:0] raw, syn;
  logic          ld_s, ad_s, hi_s;
  logic [BW-1:0] d_s;
  logic          ld_rise, ld_fall;
  logic          q_ad, q_hi, auto_q;
  logic          we;
  logic [AW-1:0] wa;
  logic [RW-1:0] wd;

  assign raw = {load_i, sel_data_i, sel_hi_i, data_i};

  tlp_sync #(.W(SW), .RST_VAL({1'b1, {(SW-1){1'b0}}})) u_sync (
    .clk_i (clk_i), .rst_ni(rst_ni), .d_i(raw), .q_o(syn)
  );

  assign {ld_s, ad_s, hi_s, d_s} = syn;

  tlp_edge #(.RST_VAL(1'b1)) u_edge (
    .clk_i (clk_i), .rst_ni(rst_ni), .lvl_i(ld_s),
    .rise_o(ld_rise), .fall_o(ld_fall)
  );

  tlp_ctrl #(.NREG(NREG), .RW(RW), .BW(BW)) u_ctrl (
    .clk_i (clk_i), .rst_ni(rst_ni),
    .rise_i(ld_rise), .fall_i(ld_fall),
    .ad_i  (ad_s), .hi_i(hi_s), .din_i(d_s),
    .q_ad_o(q_ad), .q_hi_o(q_hi), .auto_o(auto_q),
    .addr_o(addr_o),
    .we_o  (we), .wa_o(wa), .wd_o(wd)
  );

  tlp_regbank #(.NREG(NREG), .RW(RW)) u_bank (
    .clk_i (clk_i), .rst_ni(rst_ni),
    .we_i  (we), .wa_i(wa), .wd_i(wd),
    .regs_o(regs_o)
  );

  assign status_o = regs_o[RW-1:0];
endmodule

// File: rtl/tlp_chk.sv
module tlp_chk #(
  parameter int unsigned NREG = tlp_pkg::NREG,
  parameter int unsigned RW   = tlp_pkg::RW,
  parameter int unsigned BW   = tlp_pkg::BW,
  localparam int unsigned AW  = $clog2(NREG)
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic               rise,
  input logic               fall,
  input logic               q_ad,
  input logic               q_hi,
  input logic               auto_on,
  input logic [BW-1:0]      din,
  input logic [AW-1:0]      addr,
  input logic [NREG*RW-1:0] regs
);
  a_r2_one_edge: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({rise, fall}));

  a_r3_addr_load: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rise && !q_ad |=> addr == $past(din[AW-1:0]));

  a_r4_low_no_change: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rise && q_ad && !q_hi |=> $stable(regs) && $stable(addr));

  a_r6_auto_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rise && q_ad && q_hi && auto_on |=> addr == AW'($past(addr) + AW'(1)));

  a_r7_mode_set: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rise && !q_ad |=> auto_on == $past(q_hi));

  a_r7_manual_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rise && q_ad && q_hi && !auto_on |=> $stable(addr));

  a_r8_idle_stable: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rise |=> $stable(regs) && $stable(addr) && $stable(auto_on));
endmodule

bind tlp_load_port tlp_chk #(.NREG(NREG), .RW(RW), .BW(BW)) u_chk (
  .clk_i  (clk_i),
  .rst_ni (rst_ni),
  .rise   (ld_rise),
  .fall   (ld_fall),
  .q_ad   (q_ad),
  .q_hi   (q_hi),
  .auto_on(auto_q),
  .din    (d_s),
  .addr   (addr_o),
  .regs   (regs_o)
);

// File: tb/sim_tlp_load_port.sv
module sim_tlp_load_port;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         load = 1'b1;
  logic         sel_d = 1'b0;
  logic         sel_h = 1'b0;
  logic [7:0]   data = '0;
  logic [191:0] regs;
  logic [11:0]  status;
  logic [3:0]   addr;

  int errors = 0;
  int checks = 0;
  bit done = 0;

  logic [11:0] m_reg [16];
  logic [3:0]  m_addr;
  logic        m_auto;
  logic [7:0]  m_low;

  always #5ns clk = ~clk;

  tlp_load_port u0 (
    .clk_i(clk), .rst_ni(rst_n), .load_i(load), .sel_data_i(sel_d),
    .sel_hi_i(sel_h), .data_i(data), .regs_o(regs), .status_o(status),
    .addr_o(addr)
  );

  function automatic logic [11:0] dflt(input int i);
    int v;
    v = (i == 0) ? 0 : (37 * i + 100) % 4096;
    return v[11:0];
  endfunction

  task automatic model_reset();
    for (int i = 0; i < 16; i++) m_reg[i] = dflt(i);
    m_addr = '0; m_auto = 1'b0; m_low = '0;
  endtask

  task automatic model_op(input logic ad, input logic hi, input logic [7:0] d);
    if (!ad) begin
      m_addr = d[3:0]; m_auto = hi;
    end else if (!hi) begin
      m_low = d;
    end else begin
      m_reg[m_addr] = {d[3:0], m_low};
      if (m_auto) m_addr = m_addr + 4'd1;
    end
  endtask

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic check_all(input string req);
    int bad = -1;
    for (int i = 0; i < 16; i++)
      if (regs[i*12 +: 12] !== m_reg[i] && bad < 0) bad = i;
    checks++;
    if (bad >= 0) begin
      errors++;
      $display("FAIL %s reg%0d actual=%h expected=%h", req, bad, regs[bad*12 +: 12], m_reg[bad]);
    end
    chk(req, {28'd0, addr}, {28'd0, m_addr});
    chk("R9 status", {20'd0, status}, {20'd0, m_reg[0]});
  endtask

  // strobe: qualifiers valid at fall; optional change while low
  task automatic strobe(input logic ad, input logic hi, input logic [7:0] d,
                        input bit swap);
    @(negedge clk);
    sel_d = ad; sel_h = hi; data = d; load = 1'b0;
    repeat (4) @(negedge clk);
    if (swap) begin sel_d = ~ad; sel_h = ~hi; end
    repeat (2) @(negedge clk);
    load = 1'b1;
    repeat (5) @(negedge clk);
    model_op(ad, hi, d);
  endtask

  task automatic write_word(input logic [3:0] a, input logic [11:0] v);
    strobe(1'b0, 1'b0, {4'hA, a}, 0);
    strobe(1'b1, 1'b0, v[7:0], 0);
    strobe(1'b1, 1'b1, {4'h5, v[11:8]}, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5eed_0715));
    model_reset();
    repeat (3) @(negedge clk);
    check_all("R1 reset");
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    check_all("R1 after release");

    // R3: address write, upper bits ignored
    strobe(1'b0, 1'b0, 8'hF7, 0);
    check_all("R3 address");
    // R4: low byte only stages
    strobe(1'b1, 1'b0, 8'h3C, 0);
    check_all("R4 low byte");
    // R5: high nibble commits, upper bits ignored
    strobe(1'b1, 1'b1, 8'hE9, 0);
    check_all("R5 high nibble");
    chk("R5 value", {20'd0, regs[7*12 +: 12]}, 32'h93C);
    // R7: manual mode, address held
    chk("R7 addr held", {28'd0, addr}, 32'd7);
    // R9: status register write
    write_word(4'd0, 12'hABC);
    check_all("R9 status write");
    chk("R9 status value", {20'd0, status}, 32'hABC);

    // R6: auto-load across wrap
    strobe(1'b0, 1'b1, 8'h0E, 0);
    for (int k = 0; k < 4; k++) begin
      strobe(1'b1, 1'b0, 8'(8'h10 + k), 0);
      strobe(1'b1, 1'b1, 8'(k), 0);
      check_all("R6 auto step");
    end
    chk("R6 wrap addr", {28'd0, addr}, 32'd2);
    // R7: address write with hi=0 ends auto-load
    strobe(1'b0, 1'b0, 8'h05, 0);
    strobe(1'b1, 1'b1, 8'h07, 0);
    check_all("R7 auto off");

    // R2: qualifiers changed while strobe low
    strobe(1'b0, 1'b0, 8'h09, 1);
    check_all("R2 swap addr");
    strobe(1'b1, 1'b0, 8'h77, 1);
    check_all("R2 swap low");

    // R8: bus activity without strobe
    for (int k = 0; k < 20; k++) begin
      @(negedge clk);
      sel_d = 1'($urandom); sel_h = 1'($urandom); data = 8'($urandom);
    end
    repeat (4) @(negedge clk);
    check_all("R8 no strobe");

    // random mix
    for (int k = 0; k < 150; k++) begin
      logic ad, hi;
      ad = ($urandom % 4) != 0;
      hi = 1'($urandom);
      strobe(ad, hi, 8'($urandom), 0);
      check_all("R5 random");
    end

    // R1: clear mid-run
    @(negedge clk);
    rst_n = 1'b0;
    model_reset();
    @(negedge clk);
    check_all("R1 mid-run clear");
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    write_word(4'd3, 12'h5A5);
    check_all("R5 after clear");

    done = 1;
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule